// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a short conditional branch is taken and works out where it goes. It receives a 4-bit condition selector, an alternate-decode flag set when the branch carried the 0x90 prefix byte, the processor status flags (overflow, half-carry, interrupt mask, negative, zero, carry) and the level of an external interrupt line. From these it produces a taken decision. In the same pass it forms a branch target by adding a sign-extended signed displacement to the address of the following instruction.

Every condition selector comes in a pair. The even code of a pair tests one predicate and the odd code tests its complement. Without the prefix there are sixteen conditions: always and never, single-flag tests, and the signed and unsigned magnitude comparisons. With the prefix, three of the pairs are redefined as tests on the half-carry flag, the interrupt mask and the interrupt line. Every other prefixed code is flagged as illegal.

The decision, the illegal flag and the target are captured in an output register. They appear one clock after the request is presented, qualified by an output valid strobe. Fetching the branch bytes and loading the program counter are handled elsewhere.

Top module: `brcond_eval`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid`, `taken` and `illegal` are 0 and `target` is all zeros.
- R2: The results of a request presented with `in_valid`=1 at clock edge k appear on the outputs after edge k. `out_valid` is 1 in that same cycle, and back-to-back requests give back-to-back results.
- R3: Without the prefix, code 0x0 is always taken and code 0x1 is never taken. Code 0x2 is taken when C=0 and Z=0, and code 0x3 is taken when C=1 or Z=1.
- R4: Without the prefix, codes 0x4 to 0xB test one flag each. The pairs are 0x4/0x5 on C, 0x6/0x7 on Z, 0x8/0x9 on V and 0xA/0xB on N. The even code of a pair is taken when its flag is 0, and the odd code when its flag is 1. The half-carry flag has no effect on these codes.
- R5: Without the prefix, code 0xC is taken when Z=0 and N equals V, and code 0xD is taken in all other cases. Code 0xE is taken when N equals V, and code 0xF is taken when N differs from V.
- R6: With the prefix, code 0x8 is taken when H=0 and code 0x9 when H=1. Code 0xC is taken when I=0 and code 0xD when I=1. Code 0xE is taken when the interrupt line is low and code 0xF when it is high. V has no effect on codes 0x8 and 0x9.
- R7: With the prefix, codes 0x0 to 0x7, 0xA and 0xB give `illegal`=1 and `taken`=0. Without the prefix, `illegal` is always 0.
- R8: `target` equals `next_pc` plus the displacement sign-extended to the address width, taken modulo 2^ADDR_W (2^24 by default). It is computed whether or not the branch is taken.
- R9: A cycle with `in_valid`=0 gives `out_valid`=0, `taken`=0 and `illegal`=0 after the next edge, and `target` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| cond_code | input | 4 | Condition selector of the branch |
| alt_prefix | input | 1 | Branch carried the 0x90 prefix byte |
| flag_v | input | 1 | Overflow flag |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| irq_line | input | 1 | Level of the external interrupt line |
| next_pc | input | ADDR_W (24) | Address of the instruction after the branch |
| disp | input | DISP_W (8) | Signed branch displacement |
| out_valid | output | 1 | Registered result valid |
| taken | output | 1 | Branch taken |
| illegal | output | 1 | Prefixed code has no defined meaning |
| target | output | ADDR_W (24) | Branch target address |

## Verification
Two functions meet in the same cycle: the taken decision and the target sum both land in the output register on the edge that captures a request. They are provoked together by table requests that drive different addresses and displacements, and by directed requests whose sum wraps past the top or the bottom of the address space while the condition decides taken or not taken. Each result is judged field by field, decision and target together, against values worked out from the requirements. This confirms that neither function masks the other and that the target is formed even for branches that are not taken or are illegal.

// File: rtl/brc_pkg.sv
package brc_pkg;

   localparam int unsigned COND_W = 4;

   // Status flags gathered into one word for the condition decoder.
   typedef struct packed {
      logic v;
      logic h;
      logic i;
      logic n;
      logic z;
      logic c;
   } brc_flags_t;

   // Condition pairs: code[3:1] picks the pair and code[0] selects the complement.
   typedef enum logic [2:0] {
      PR_ALWAYS = 3'd0,
      PR_UGT    = 3'd1,
      PR_CCLR   = 3'd2,
      PR_ZCLR   = 3'd3,
      PR_VCLR   = 3'd4,
      PR_NCLR   = 3'd5,
      PR_SGT    = 3'd6,
      PR_SGE    = 3'd7
   } brc_pair_t;

endpackage

// File: rtl/brc_cond_decode.sv
module brc_cond_decode
   import brc_pkg::*;
(
   input  logic [COND_W-1:0] code,
   input  logic              alt,
   input  brc_flags_t        flags,
   input  logic              irq,
   output logic              take,
   output logic              bad
);

   brc_pair_t pair;
   logic      even_true;
   logic      n_eq_v;

   assign pair   = brc_pair_t'(code[COND_W-1:1]);
   assign n_eq_v = ~(flags.n ^ flags.v);

   always_comb begin
      even_true = 1'b0;
      bad       = 1'b0;
      if (alt) begin
         unique case (pair)
            PR_VCLR: even_true = ~flags.h;
            PR_SGT:  even_true = ~flags.i;
            PR_SGE:  even_true = ~irq;
            default: bad       = 1'b1;
         endcase
      end else begin
         unique case (pair)
            PR_ALWAYS: even_true = 1'b1;
            PR_UGT:    even_true = ~(flags.c | flags.z);
            PR_CCLR:   even_true = ~flags.c;
            PR_ZCLR:   even_true = ~flags.z;
            PR_VCLR:   even_true = ~flags.v;
            PR_NCLR:   even_true = ~flags.n;
            PR_SGT:    even_true = ~flags.z & n_eq_v;
            PR_SGE:    even_true = n_eq_v;
            default:   even_true = 1'b0;
         endcase
      end
      take = bad ? 1'b0 : (even_true ^ code[0]);
   end

endmodule

// File: rtl/brc_target_add.sv
module brc_target_add #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DISP_W = 8
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [DISP_W-1:0] disp,
   output logic [ADDR_W-1:0] sum
);

   localparam int unsigned EXT_W = (ADDR_W > DISP_W) ? (ADDR_W - DISP_W) : 1;

   logic [ADDR_W-1:0] disp_ext;

   generate
      if (DISP_W < 2) begin : g_bad_disp
         $error("brc_target_add: DISP_W must be at least 2");
      end
      if (ADDR_W < DISP_W) begin : g_bad_addr
         $error("brc_target_add: ADDR_W must not be below DISP_W");
      end

      if (ADDR_W > DISP_W) begin : g_sext
         assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
      end else begin : g_same
         assign disp_ext = disp[ADDR_W-1:0];
      end
   endgenerate

   assign sum = base + disp_ext;

endmodule

// File: rtl/brcond_eval.sv
module brcond_eval
   import brc_pkg::*;
#(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DISP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        cond_code,
   input  logic              alt_prefix,
   input  logic              flag_v,
   input  logic              flag_h,
   input  logic              flag_i,
   input  logic              flag_n,
   input  logic              flag_z,
   input  logic              flag_c,
   input  logic              irq_line,
   input  logic [ADDR_W-1:0] next_pc,
   input  logic [DISP_W-1:0] disp,
   output logic              out_valid,
   output logic              taken,
   output logic              illegal,
   output logic [ADDR_W-1:0] target
);

   generate
      if (COND_W != 4) begin : g_bad_cond
         $error("brcond_eval: condition field must be 4 bits");
      end
   endgenerate

   brc_flags_t        flags;
   logic              dec_take;
   logic              dec_bad;
   logic [ADDR_W-1:0] sum;

   assign flags = '{v: flag_v, h: flag_h, i: flag_i, n: flag_n, z: flag_z, c: flag_c};

   brc_cond_decode u_decode (
      .code  (cond_code),
      .alt   (alt_prefix),
      .flags (flags),
      .irq   (irq_line),
      .take  (dec_take),
      .bad   (dec_bad)
   );

   brc_target_add #(
      .ADDR_W (ADDR_W),
      .DISP_W (DISP_W)
   ) u_add (
      .base (next_pc),
      .disp (disp),
      .sum  (sum)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         taken     <= 1'b0;
         illegal   <= 1'b0;
         target    <= '0;
      end else begin
         out_valid <= in_valid;
         taken     <= in_valid & dec_take;
         illegal   <= in_valid & dec_bad;
         if (in_valid) begin
            target <= sum;
         end
      end
   end

endmodule

// File: rtl/brcond_eval_chk.sv
module brcond_eval_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned DISP_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        cond_code,
   input logic              alt_prefix,
   input logic              irq_line,
   input logic [ADDR_W-1:0] next_pc,
   input logic [DISP_W-1:0] disp,
   input logic              out_valid,
   input logic              taken,
   input logic              illegal,
   input logic [ADDR_W-1:0] target
);

   logic [ADDR_W-1:0] exp_tgt;
   assign exp_tgt = next_pc + ADDR_W'($signed(disp));

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && !taken && !illegal));

   a_r9_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(target));

   a_r7_illegal_not_taken: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> !taken);

   a_r7_plain_never_illegal: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !alt_prefix) |=> !illegal);

   a_r8_target_sum: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (target == $past(exp_tgt)));

   a_r3_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !alt_prefix && cond_code == 4'h0) |=> taken);

   a_r3_never_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !alt_prefix && cond_code == 4'h1) |=> !taken);

   a_r6_line_low: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && alt_prefix && cond_code == 4'hE) |=> (taken == !$past(irq_line)));

endmodule

bind brcond_eval brcond_eval_chk #(
   .ADDR_W (ADDR_W),
   .DISP_W (DISP_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .cond_code  (cond_code),
   .alt_prefix (alt_prefix),
   .irq_line   (irq_line),
   .next_pc    (next_pc),
   .disp       (disp),
   .out_valid  (out_valid),
   .taken      (taken),
   .illegal    (illegal),
   .target     (target)
);

// File: tb/brcond_eval_bench.sv
`timescale 1ns/1ps
module brcond_eval_bench;

   localparam int unsigned ADDR_W = 24;
   localparam int unsigned DISP_W = 8;
   localparam int NVEC = 32;

   // {prefix, code[3:0], v, h, i, n, z, c, irq, exp_taken, exp_illegal}
   localparam logic [13:0] VEC [NVEC] = '{
      14'b0_0000_000000_0_1_0,
      14'b0_0001_111111_1_0_0,
      14'b0_0010_000000_0_1_0,
      14'b0_0010_000001_0_0_0,
      14'b0_0011_000010_0_1_0,
      14'b0_0011_000000_0_0_0,
      14'b0_0100_000000_0_1_0,
      14'b0_0101_000001_0_1_0,
      14'b0_0110_000010_0_0_0,
      14'b0_0111_000010_0_1_0,
      14'b0_1000_100000_0_0_0,
      14'b0_1001_100000_0_1_0,
      14'b0_1010_000100_0_0_0,
      14'b0_1011_000100_0_1_0,
      14'b0_1100_100100_0_1_0,
      14'b0_1100_100110_0_0_0,
      14'b0_1101_000100_0_1_0,
      14'b0_1110_000010_0_1_0,
      14'b0_1111_100000_0_1_0,
      14'b0_1000_010000_0_1_0,
      14'b1_1000_010000_0_0_0,
      14'b1_1001_010000_0_1_0,
      14'b1_1001_100000_0_0_0,
      14'b1_1100_001000_0_0_0,
      14'b1_1101_001000_0_1_0,
      14'b1_1110_000000_0_1_0,
      14'b1_1111_000000_1_1_0,
      14'b1_1111_000000_0_0_0,
      14'b1_0000_000000_0_0_1,
      14'b1_0110_000010_0_0_1,
      14'b1_1011_000100_0_0_1,
      14'b1_1010_000000_0_0_1
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic [3:0]        cond_code = '0;
   logic              alt_prefix = 1'b0;
   logic              flag_v = 1'b0, flag_h = 1'b0, flag_i = 1'b0;
   logic              flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
   logic              irq_line = 1'b0;
   logic [ADDR_W-1:0] next_pc = '0;
   logic [DISP_W-1:0] disp = '0;
   logic              out_valid, taken, illegal;
   logic [ADDR_W-1:0] target;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   brcond_eval #(.ADDR_W(ADDR_W), .DISP_W(DISP_W)) u_brcond_eval (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cond_code(cond_code),
      .alt_prefix(alt_prefix), .flag_v(flag_v), .flag_h(flag_h), .flag_i(flag_i),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .irq_line(irq_line),
      .next_pc(next_pc), .disp(disp), .out_valid(out_valid), .taken(taken),
      .illegal(illegal), .target(target)
   );

   function automatic logic [ADDR_W-1:0] ref_target(logic [ADDR_W-1:0] pc, logic [DISP_W-1:0] d);
      return pc + ADDR_W'($signed(d));
   endfunction

   task automatic check(string req, logic v, logic t, logic il, logic [ADDR_W-1:0] tg,
                        logic ev, logic et, logic eil, logic [ADDR_W-1:0] etg);
      checks++;
      if (v !== ev || t !== et || il !== eil || tg !== etg) begin
         failures++;
         $display("FAIL %s valid/taken/illegal/target actual=%b/%b/%b/%h expected=%b/%b/%b/%h",
                  req, v, t, il, tg, ev, et, eil, etg);
      end
   endtask

   task automatic drive(logic p, logic [3:0] code, logic [5:0] f, logic irq,
                        logic [ADDR_W-1:0] pc, logic [DISP_W-1:0] d);
      in_valid   = 1'b1;
      alt_prefix = p;
      cond_code  = code;
      {flag_v, flag_h, flag_i, flag_n, flag_z, flag_c} = f;
      irq_line   = irq;
      next_pc    = pc;
      disp       = d;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [ADDR_W-1:0] prev_tgt;
      repeat (3) @(negedge clk);
      // R1: outputs in reset
      check("R1", out_valid, taken, illegal, target, 1'b0, 1'b0, 1'b0, '0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", out_valid, taken, illegal, target, 1'b0, 1'b0, 1'b0, '0);

      // Table walk, requests back to back (R2)
      for (int k = 0; k < NVEC; k++) begin
         logic [13:0] e = VEC[k];
         logic [ADDR_W-1:0] pc = ADDR_W'(k * 24'h0A3C57 + 24'h123456);
         logic [DISP_W-1:0] d  = DISP_W'(k * 53 + 7);
         string req;
         drive(e[13], e[12:9], e[8:3], e[2], pc, d);
         @(negedge clk);
         if (e[0])              req = "R7";
         else if (e[13])        req = "R6";
         else if (e[12:9] < 4)  req = "R3";
         else if (e[12:9] < 12) req = "R4";
         else                   req = "R5";
         check({req, "/R2/R8"}, out_valid, taken, illegal, target,
               1'b1, e[1], e[0], ref_target(pc, d));
      end

      // R8: wrap past the top, branch taken
      drive(1'b0, 4'h0, 6'b0, 1'b0, 24'hFFFFF0, 8'h20);
      @(negedge clk);
      check("R8", out_valid, taken, illegal, target, 1'b1, 1'b1, 1'b0, 24'h000010);
      // R8: wrap below zero, branch not taken
      drive(1'b0, 4'h1, 6'b0, 1'b0, 24'h000005, 8'h80);
      @(negedge clk);
      check("R8", out_valid, taken, illegal, target, 1'b1, 1'b0, 1'b0, 24'hFFFF85);
      // R8: target still formed for an illegal prefixed code
      drive(1'b1, 4'h2, 6'b0, 1'b0, 24'h00ABCD, 8'h7F);
      @(negedge clk);
      check("R8", out_valid, taken, illegal, target, 1'b1, 1'b0, 1'b1, 24'h00AC4C);
      prev_tgt = 24'h00AC4C;

      // R9: idle cycle with inputs that would otherwise give taken
      in_valid = 1'b0;
      alt_prefix = 1'b0; cond_code = 4'h0; next_pc = 24'h111111; disp = 8'h01;
      @(negedge clk);
      check("R9", out_valid, taken, illegal, target, 1'b0, 1'b0, 1'b0, prev_tgt);
      // R9: idle with an illegal code present
      alt_prefix = 1'b1; cond_code = 4'h3;
      @(negedge clk);
      check("R9", out_valid, taken, illegal, target, 1'b0, 1'b0, 1'b0, prev_tgt);

      // R6: line high, code 0xE not taken; R4 flag h does not affect code 9
      drive(1'b1, 4'hE, 6'b0, 1'b1, 24'h000100, 8'hFE);
      @(negedge clk);
      check("R6", out_valid, taken, illegal, target, 1'b1, 1'b0, 1'b0, 24'h0000FE);
      drive(1'b0, 4'h9, 6'b010000, 1'b1, 24'h000100, 8'h00);
      @(negedge clk);
      check("R4", out_valid, taken, illegal, target, 1'b1, 1'b0, 1'b0, 24'h000100);
      in_valid = 1'b0;

      // R1: reset in mid-run clears outputs
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R1", out_valid, taken, illegal, target, 1'b0, 1'b0, 1'b0, '0);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule